// File: doc/BRIEF.md
# Pulsed-Power Duty-Cycle Sequencer

This block steps a low-power front-end chip through the repeating cycle of a pulsed accelerator: a long sleep with the analog parts at a very low bias current, a wake-up with a settling wait, signal acquisition, on-chip A/D conversion, and digital readout. Trains of beam arrive about every 200 ms. Acquisition, conversion and readout together take about 2 ms. The rest of the period is sleep. The block never leaves sleep by itself. A one-cycle train-start pulse wakes it. It then drives the analog bias enable, the converter enable and the readout enable in turn, and it reports the current phase on a 2-bit code.

Raising the bias does not make the analog front end usable at once. It needs up to about 20 µs to settle. The block keeps its ready flag low for a programmable number of cycles after the bias enable rises, and the acquisition window is counted only after that wait. The lengths of the settling wait and of the three active phases come in on input ports. They are copied into shadow registers only when the block enters sleep, so a change made during a train takes effect one train later. A train-start pulse that arrives while the block is busy has no effect on the sequence and increments a saturating error counter.

Top module: `pwr_seq`

## Requirements
- R1: While reset is asserted and right after it is released, the phase code is 0 (sleep), all enables and the ready flag are low, and the error count is 0.
- R2: When train_i is high in a cycle in sleep, the next cycle shows phase code 1 (acquisition) with bias_en_o high.
- R3: After bias_en_o rises, ready_o stays low for exactly S cycles and then goes high, where S is the loaded settling length. With S = 0, ready_o is high in the first acquisition cycle.
- R4: Phase code 1 lasts S + A cycles, then phase code 2 (conversion) lasts C cycles, then phase code 3 (readout) lasts R cycles, and then the block returns to code 0. A loaded length of 0 for A, C or R acts as 1.
- R5: The phase code only ever advances 0→1→2→3→0, one step at a time.
- R6: bias_en_o is high exactly in codes 1 and 2, adc_en_o exactly in code 2, and rd_en_o exactly in code 3. In code 0 all enables are low.
- R7: train_i high in any cycle outside sleep leaves the phase sequence unchanged and increments err_cnt_o by 1.
- R8: err_cnt_o saturates at 2^ERR_W − 1 and holds there.
- R9: The length inputs are sampled only on the cycle the block enters sleep and in the first cycle after reset. A train uses the values sampled at the preceding sleep entry.
- R10: ready_o is never high while bias_en_o is low. It returns low when conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| train_i | input | 1 | One-cycle train-start pulse |
| settle_len_i | input | LEN_W | Settling wait in cycles |
| acq_len_i | input | LEN_W | Acquisition length in cycles |
| conv_len_i | input | LEN_W | Conversion length in cycles |
| read_len_i | input | LEN_W | Readout length in cycles |
| phase_o | output | 2 | Phase code: 0 sleep, 1 acquisition, 2 conversion, 3 readout |
| bias_en_o | output | 1 | Analog bias at nominal current |
| adc_en_o | output | 1 | Converter enable |
| rd_en_o | output | 1 | Readout logic enable |
| ready_o | output | 1 | Analog front end settled |
| err_cnt_o | output | ERR_W | Saturating count of train pulses received while busy |

## Verification
Two situations are hard to reach from the ports. The first is saturating the error counter, because every cycle with a stray pulse must fall inside a train. The stimulus loads long phase lengths and then holds train_i high for every busy cycle of two trains, which pushes the count past its ceiling. The second is the one-train lag of the length registers. The bench changes the length inputs while the block sleeps and checks that the next train still runs the old timing and only the train after it runs the new timing. A per-cycle model of the expected phase, enables and ready flag checks each case, including zero lengths.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2,
        PH_READ = 2'd3
    } phase_e;
endpackage

// File: rtl/pwr_seq_cfg.sv
// Shadow copies of the phase lengths, refreshed only at sleep entry.
module pwr_seq_cfg #(
    parameter int LEN_W      = 24,
    parameter int DEF_SETTLE = 1000,
    parameter int DEF_ACQ    = 50000,
    parameter int DEF_CONV   = 25000,
    parameter int DEF_READ   = 25000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [LEN_W-1:0] settle_len_i,
    input  logic [LEN_W-1:0] acq_len_i,
    input  logic [LEN_W-1:0] conv_len_i,
    input  logic [LEN_W-1:0] read_len_i,
    output logic [LEN_W-1:0] settle_o,
    output logic [LEN_W-1:0] acq_o,
    output logic [LEN_W-1:0] conv_o,
    output logic [LEN_W-1:0] read_o
);
    typedef struct packed {
        logic             first;
        logic [LEN_W-1:0] settle;
        logic [LEN_W-1:0] acq;
        logic [LEN_W-1:0] conv;
        logic [LEN_W-1:0] rd;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.first = 1'b0;
        if (load_i || c_q.first) begin
            c_d.settle = settle_len_i;
            c_d.acq    = acq_len_i;
            c_d.conv   = conv_len_i;
            c_d.rd     = read_len_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.first  <= 1'b1;
            c_q.settle <= LEN_W'(DEF_SETTLE);
            c_q.acq    <= LEN_W'(DEF_ACQ);
            c_q.conv   <= LEN_W'(DEF_CONV);
            c_q.rd     <= LEN_W'(DEF_READ);
        end else begin
            c_q <= c_d;
        end
    end

    assign settle_o = c_q.settle;
    assign acq_o    = c_q.acq;
    assign conv_o   = c_q.conv;
    assign read_o   = c_q.rd;
endmodule

// File: rtl/pwr_seq_fsm.sv
// Phase state machine with one shared cycle counter.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             train_i,
    input  logic [LEN_W-1:0] settle_i,
    input  logic [LEN_W-1:0] acq_i,
    input  logic [LEN_W-1:0] conv_i,
    input  logic [LEN_W-1:0] read_i,
    output phase_e           phase_o,
    output logic             ready_o,
    output logic             idle_entry_o
);
    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] cnt;
        logic             ready;
    } st_t;

    st_t s_d, s_q;

    // True on the last cycle of a window of length l (0 behaves as 1).
    function automatic logic hit(input logic [LEN_W-1:0] c, input logic [LEN_W-1:0] l);
        return ({1'b0, c} + (LEN_W+1)'(1)) >= {1'b0, l};
    endfunction

    always_comb begin
        s_d          = s_q;
        idle_entry_o = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (train_i) begin
                    s_d.phase = PH_ACQ;
                    s_d.cnt   = '0;
                    s_d.ready = (settle_i == '0);
                end
            end
            PH_ACQ: begin
                if (!s_q.ready) begin
                    if (hit(s_q.cnt, settle_i)) begin
                        s_d.ready = 1'b1;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + LEN_W'(1);
                    end
                end else if (hit(s_q.cnt, acq_i)) begin
                    s_d.phase = PH_CONV;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + LEN_W'(1);
                end
            end
            PH_CONV: begin
                if (hit(s_q.cnt, conv_i)) begin
                    s_d.phase = PH_READ;
                    s_d.cnt   = '0;
                    s_d.ready = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + LEN_W'(1);
                end
            end
            default: begin
                if (hit(s_q.cnt, read_i)) begin
                    s_d.phase    = PH_IDLE;
                    s_d.cnt      = '0;
                    idle_entry_o = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + LEN_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.ready <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign ready_o = s_q.ready;
endmodule

// File: rtl/pwr_seq_errcnt.sv
// Saturating count of train pulses seen while a train is in progress.
module pwr_seq_errcnt #(
    parameter int ERR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             train_i,
    input  logic             busy_i,
    output logic [ERR_W-1:0] cnt_o
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic [ERR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (train_i && busy_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + ERR_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int ERR_W      = 8,
    parameter int DEF_SETTLE = 1000,
    parameter int DEF_ACQ    = 50000,
    parameter int DEF_CONV   = 25000,
    parameter int DEF_READ   = 25000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             train_i,
    input  logic [LEN_W-1:0] settle_len_i,
    input  logic [LEN_W-1:0] acq_len_i,
    input  logic [LEN_W-1:0] conv_len_i,
    input  logic [LEN_W-1:0] read_len_i,
    output logic [1:0]       phase_o,
    output logic             bias_en_o,
    output logic             adc_en_o,
    output logic             rd_en_o,
    output logic             ready_o,
    output logic [ERR_W-1:0] err_cnt_o
);
    logic [LEN_W-1:0] settle_q, acq_q, conv_q, read_q;
    logic             idle_entry;
    phase_e           phase;

    pwr_seq_cfg #(
        .LEN_W(LEN_W), .DEF_SETTLE(DEF_SETTLE), .DEF_ACQ(DEF_ACQ),
        .DEF_CONV(DEF_CONV), .DEF_READ(DEF_READ)
    ) u_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(idle_entry),
        .settle_len_i(settle_len_i), .acq_len_i(acq_len_i),
        .conv_len_i(conv_len_i), .read_len_i(read_len_i),
        .settle_o(settle_q), .acq_o(acq_q), .conv_o(conv_q), .read_o(read_q)
    );

    pwr_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .train_i(train_i),
        .settle_i(settle_q), .acq_i(acq_q), .conv_i(conv_q), .read_i(read_q),
        .phase_o(phase), .ready_o(ready_o), .idle_entry_o(idle_entry)
    );

    pwr_seq_errcnt #(.ERR_W(ERR_W)) u_err (
        .clk_i(clk_i), .rst_ni(rst_ni), .train_i(train_i),
        .busy_i(phase != PH_IDLE), .cnt_o(err_cnt_o)
    );

    assign phase_o   = phase;
    assign bias_en_o = (phase == PH_ACQ) || (phase == PH_CONV);
    assign adc_en_o  = (phase == PH_CONV);
    assign rd_en_o   = (phase == PH_READ);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int ERR_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             train_i,
    input logic [1:0]       phase_o,
    input logic             bias_en_o,
    input logic             adc_en_o,
    input logic             rd_en_o,
    input logic             ready_o,
    input logic [ERR_W-1:0] err_cnt_o
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    a_r2_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 2'd0 && train_i) |=> (phase_o == 2'd1 && bias_en_o));

    a_r5_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o != $past(phase_o)) |-> (phase_o == $past(phase_o) + 2'd1));

    a_r6_adc_with_bias: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_en_o |-> (bias_en_o && !rd_en_o));

    a_r6_read_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_o |-> !bias_en_o);

    a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 2'd0) |-> !(bias_en_o || adc_en_o || rd_en_o || ready_o));

    a_r7_count_stray: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (train_i && phase_o != 2'd0 && err_cnt_o != CNT_MAX)
        |=> (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));

    a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_cnt_o == CNT_MAX) |=> (err_cnt_o == CNT_MAX));

    a_r10_ready_needs_bias: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> bias_en_o);
endmodule

bind pwr_seq pwr_seq_chk #(.ERR_W(ERR_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .train_i(train_i), .phase_o(phase_o),
    .bias_en_o(bias_en_o), .adc_en_o(adc_en_o), .rd_en_o(rd_en_o),
    .ready_o(ready_o), .err_cnt_o(err_cnt_o)
);

// File: tb/pwr_seq_tb.sv
module pwr_seq_tb;
    localparam int LEN_W = 24;
    localparam int ERR_W = 8;
    localparam int EMAX  = (1 << ERR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             train = 1'b0;
    logic [LEN_W-1:0] s_len = 3, a_len = 4, c_len = 2, r_len = 2;
    logic [1:0]       phase;
    logic             bias, adc, rd, ready;
    logic [ERR_W-1:0] err;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    int ls, la, lc, lr;
    int exp_err = 0;

    always #10 clk = ~clk;

    pwr_seq #(.LEN_W(LEN_W), .ERR_W(ERR_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .train_i(train),
        .settle_len_i(s_len), .acq_len_i(a_len), .conv_len_i(c_len), .read_len_i(r_len),
        .phase_o(phase), .bias_en_o(bias), .adc_en_o(adc), .rd_en_o(rd),
        .ready_o(ready), .err_cnt_o(err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One full train with a per-cycle model; inject holds train high while busy.
    task automatic run_train(input bit inject);
        int s, a, c, r, n;
        s = ls; a = (la == 0) ? 1 : la; c = (lc == 0) ? 1 : lc; r = (lr == 0) ? 1 : lr;
        n = s + a + c + r;
        @(negedge clk);
        train = 1'b1;
        for (int k = 0; k < n; k++) begin
            int ep, eb, ea, er, ey;
            @(negedge clk);
            train = inject;
            ep = (k < s + a) ? 1 : (k < s + a + c) ? 2 : 3;
            eb = (ep == 1 || ep == 2); ea = (ep == 2); er = (ep == 3);
            ey = (k >= s && k < s + a + c);
            chk(phase == 2'(ep), (k == 0) ? "R2" : "R4", "phase", phase, ep);
            chk({bias, adc, rd} == {1'(eb), 1'(ea), 1'(er)}, "R6", "enables", {bias, adc, rd}, {eb[0], ea[0], er[0]});
            chk(ready == 1'(ey), (ey == 1) ? "R3" : "R10", "ready", ready, ey);
        end
        if (inject) exp_err = (exp_err + n > EMAX) ? EMAX : exp_err + n;
        @(negedge clk);
        train = 1'b0;
        chk(phase == 2'd0, "R4", "phase after readout", phase, 0);
        chk(err == ERR_W'(exp_err), inject ? "R7/R8" : "R7", "err count", err, exp_err);
        ls = s_len; la = a_len; lc = c_len; lr = r_len;
        repeat (2) @(negedge clk);
        chk(phase == 2'd0 && !bias, "R5", "stays asleep", phase, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(phase == 2'd0, "R1", "phase in reset", phase, 0);
        chk({bias, adc, rd, ready} == 4'b0, "R1", "outputs in reset", {bias, adc, rd, ready}, 0);
        rst_n = 1'b1;
        ls = s_len; la = a_len; lc = c_len; lr = r_len;
        repeat (2) @(negedge clk);
        chk(phase == 2'd0 && !bias && !ready, "R1", "idle after reset", phase, 0);
        chk(err == '0, "R1", "err after reset", err, 0);
    endtask

    task automatic t_basic;
        run_train(1'b0);
    endtask

    task automatic t_cfg_lag;
        s_len = 0; a_len = 1; c_len = 1; r_len = 1;
        run_train(1'b0);  // R9: old lengths still in force
        chk(ls == 0 && la == 1, "R9", "model loaded new lengths", ls, 0);
        run_train(1'b0);  // R3 with zero settling, R9 new lengths
    endtask

    task automatic t_zero_len;
        s_len = 2; a_len = 0; c_len = 0; r_len = 0;
        run_train(1'b0);
        s_len = 1; a_len = 3; c_len = 2; r_len = 2;
        run_train(1'b0);  // R4 zero lengths act as one
    endtask

    task automatic t_stray;
        run_train(1'b1);  // R7 stray pulses ignored and counted
    endtask

    task automatic t_saturate;
        s_len = 5; a_len = 200; c_len = 20; r_len = 40;
        run_train(1'b1);
        run_train(1'b1);  // R8 counter holds at maximum
        chk(err == ERR_W'(EMAX), "R8", "saturated", err, EMAX);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_cfg_lag();
        t_zero_len();
        t_stray();
        t_saturate();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule